// File: doc/BRIEF.md
# Converter Output Clamp and Register

This block is the last stage of a converter data path. Each time an upstream stage marks a corrected result as ready, the block takes the wider result word and reduces it to a straight-binary data word and a separate overrange flag. Both are registered on the rising clock edge. When the result is at or above the top of the data range, the flag is raised and every data bit is driven to one. A downstream system with more resolution can then extend the range with the flag while it sees a saturated code.

An active-low output enable controls whether the outputs are driven. When the enable is high, every output bit is released to high impedance. The block shows this as one output-enable line per bit, so the off-chip pad ring or a bench can model the tri-state drivers. The enable has no effect on the stored word. A synchronous reset clears the word and the flag.

Top module: `out_code_clamp`

## Requirements
- R1: When `in_valid` is 1 and `in_code` is below 1024 at a rising edge, `data_o` after that edge equals `in_code[9:0]` and `ovr_o` is 0. Code 0 is the bottom of the range and 1023 (all ones) is full scale.
- R2: When `in_valid` is 1 and `in_code` is 1024 or above at a rising edge, `ovr_o` is 1 after that edge.
- R3: Whenever `ovr_o` is 1, every bit of `data_o` is 1.
- R4: The outputs change only at a rising clock edge. A new `in_code` applied between edges is not visible before the next edge.
- R5: When `in_valid` is 0 at a rising edge, `data_o` and `ovr_o` keep their previous values.
- R6: While `out_en_n` is 1, every bit of `data_oe` and `ovr_oe` is 0 (high impedance). While `out_en_n` is 0, all of them are 1.
- R7: `out_en_n` does not affect the stored word. A word captured while the outputs are released appears on `data_o` and `ovr_o` once they are enabled again.
- R8: With `rst` high at a rising edge, `data_o` and `ovr_o` become 0 after that edge.
- R9: An in-range word captured right after an overrange word clears `ovr_o` and shows its own code, not the saturated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_code` as a new result to capture |
| in_code | input | 11 | Corrected result word, unsigned |
| out_en_n | input | 1 | Output enable, active low; high releases all outputs |
| data_o | output | 10 | Registered straight-binary data word |
| ovr_o | output | 1 | Registered overrange flag |
| data_oe | output | 10 | Per-bit drive enable for `data_o` (1 = driven) |
| ovr_oe | output | 1 | Drive enable for `ovr_o` (1 = driven) |

## Verification
The bench focuses on the boundary around 1023 and 1024. A comparison that is off by one, or one that looks only at the top bit, would flag full scale as overrange or let 1024 through as code 0. It also checks 2047 and mixed upper-bit patterns. Without saturation these would leak their low bits onto `data_o` next to a raised flag. An in-range word directly after an overrange word catches a sticky flag. Holding with `in_valid` low catches a register that loads on every cycle. A sample taken before the edge catches a transparent path. A capture made while the outputs are released catches an enable that wrongly gates the register instead of only the drivers.

// File: rtl/out_code_clamp_pkg.sv
package out_code_clamp_pkg;
    // Default widths of the result word and the straight-binary data word.
    localparam int unsigned DEF_IN_W  = 11;
    localparam int unsigned DEF_OUT_W = 10;

    // Drive state of the output pads.
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drive_e;
endpackage

// File: rtl/code_sat_decode.sv
module code_sat_decode #(
    parameter int unsigned IN_W  = out_code_clamp_pkg::DEF_IN_W,
    parameter int unsigned OUT_W = out_code_clamp_pkg::DEF_OUT_W
) (
    input  logic [IN_W-1:0]  raw_code,
    output logic [OUT_W-1:0] sat_code,
    output logic             over_flag
);
    localparam logic [OUT_W-1:0] ALL_ONES = {OUT_W{1'b1}};

    // A result is over range when any bit above the data field is set.
    generate
        if (IN_W > OUT_W) begin : g_has_headroom
            assign over_flag = |raw_code[IN_W-1:OUT_W];
        end else begin : g_no_headroom
            assign over_flag = 1'b0;
        end
    endgenerate

    always_comb begin
        if (over_flag) begin
            sat_code = ALL_ONES;
        end else begin
            sat_code = raw_code[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/out_word_reg.sv
module out_word_reg #(
    parameter int unsigned OUT_W = out_code_clamp_pkg::DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] code_in,
    input  logic             over_in,
    output logic [OUT_W-1:0] code_q_o,
    output logic             over_q_o
);
    typedef struct packed {
        logic [OUT_W-1:0] code;
        logic             over;
    } word_t;

    word_t word_d;
    word_t word_q;

    always_comb begin
        word_d = word_q;
        if (load) begin
            word_d.code = code_in;
            word_d.over = over_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign code_q_o = word_q.code;
    assign over_q_o = word_q.over;
endmodule

// File: rtl/pad_drive_ctl.sv
module pad_drive_ctl #(
    parameter int unsigned OUT_W = out_code_clamp_pkg::DEF_OUT_W
) (
    input  logic             release_n_i,
    output logic [OUT_W-1:0] data_oe_o,
    output logic             ovr_oe_o
);
    import out_code_clamp_pkg::*;

    drive_e drive_state;

    always_comb begin
        drive_state = release_n_i ? DRV_OFF : DRV_ON;
    end

    generate
        for (genvar b = 0; b < OUT_W; b++) begin : g_bit_oe
            assign data_oe_o[b] = (drive_state == DRV_ON);
        end
    endgenerate

    assign ovr_oe_o = (drive_state == DRV_ON);
endmodule

// File: rtl/out_code_clamp.sv
module out_code_clamp #(
    parameter int unsigned IN_W  = out_code_clamp_pkg::DEF_IN_W,
    parameter int unsigned OUT_W = out_code_clamp_pkg::DEF_OUT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_code,
    input  logic             out_en_n,
    output logic [OUT_W-1:0] data_o,
    output logic             ovr_o,
    output logic [OUT_W-1:0] data_oe,
    output logic             ovr_oe
);
    logic [OUT_W-1:0] sat_code;
    logic             over_flag;

    code_sat_decode #(
        .IN_W  (IN_W),
        .OUT_W (OUT_W)
    ) u_decode (
        .raw_code  (in_code),
        .sat_code  (sat_code),
        .over_flag (over_flag)
    );

    out_word_reg #(
        .OUT_W (OUT_W)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .load     (in_valid),
        .code_in  (sat_code),
        .over_in  (over_flag),
        .code_q_o (data_o),
        .over_q_o (ovr_o)
    );

    pad_drive_ctl #(
        .OUT_W (OUT_W)
    ) u_drive (
        .release_n_i (out_en_n),
        .data_oe_o   (data_oe),
        .ovr_oe_o    (ovr_oe)
    );
endmodule

// File: rtl/out_code_clamp_chk.sv
module out_code_clamp_chk #(
    parameter int unsigned IN_W  = out_code_clamp_pkg::DEF_IN_W,
    parameter int unsigned OUT_W = out_code_clamp_pkg::DEF_OUT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_code,
    input logic             out_en_n,
    input logic [OUT_W-1:0] data_o,
    input logic             ovr_o,
    input logic [OUT_W-1:0] data_oe,
    input logic             ovr_oe
);
    localparam logic [IN_W-1:0] TOP = IN_W'(1) << OUT_W;

    AST_IN_RANGE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code < TOP) |=> (data_o == $past(in_code[OUT_W-1:0]) && !ovr_o)); // R1

    AST_OVER_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_code >= TOP) |=> ovr_o); // R2

    AST_OVER_SATURATES: assert property (@(posedge clk) disable iff (rst)
        ovr_o |-> (&data_o)); // R3

    AST_HOLD_WITHOUT_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(data_o) && $stable(ovr_o))); // R5

    AST_RELEASED_PADS: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (data_oe == '0 && !ovr_oe)); // R6

    AST_DRIVEN_PADS: assert property (@(posedge clk) disable iff (rst)
        !out_en_n |-> ((&data_oe) && ovr_oe)); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (data_o == '0 && !ovr_o)); // R8
endmodule

bind out_code_clamp out_code_clamp_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_code  (in_code),
    .out_en_n (out_en_n),
    .data_o   (data_o),
    .ovr_o    (ovr_o),
    .data_oe  (data_oe),
    .ovr_oe   (ovr_oe)
);

// File: tb/test_out_code_clamp.sv
module test_out_code_clamp;
    localparam int IN_W  = 11;
    localparam int OUT_W = 10;
    localparam int NVEC  = 12;

    // Each entry: {in_code[10:0], expected data[9:0], expected flag}
    localparam logic [21:0] VEC [NVEC] = '{
        {11'd0,    10'h000, 1'b0},  // R1 bottom of range
        {11'd1,    10'h001, 1'b0},  // R1
        {11'd512,  10'h200, 1'b0},  // R1 mid scale
        {11'h155,  10'h155, 1'b0},  // R1 alternating bits
        {11'h2AA,  10'h2AA, 1'b0},  // R1 alternating bits
        {11'd1023, 10'h3FF, 1'b0},  // R1 full scale, no flag
        {11'd1024, 10'h3FF, 1'b1},  // R2 R3 first overrange code
        {11'd5,    10'h005, 1'b0},  // R9 leaves overrange
        {11'd1025, 10'h3FF, 1'b1},  // R2 R3 low bits must not leak
        {11'd1500, 10'h3FF, 1'b1},  // R2 R3
        {11'd2047, 10'h3FF, 1'b1},  // R2 R3 top code
        {11'd1022, 10'h3FE, 1'b0}   // R9 back below full scale
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [IN_W-1:0]  in_code = '0;
    logic             out_en_n = 1'b0;
    logic [OUT_W-1:0] data_o;
    logic             ovr_o;
    logic [OUT_W-1:0] data_oe;
    logic             ovr_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    out_code_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) i_out_code_clamp (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_code  (in_code),
        .out_en_n (out_en_n),
        .data_o   (data_o),
        .ovr_o    (ovr_o),
        .data_oe  (data_oe),
        .ovr_oe   (ovr_oe)
    );

    task automatic check_word(input string req, input logic [OUT_W-1:0] ed, input logic eo);
        checks++;
        if (data_o !== ed || ovr_o !== eo) begin
            fails++;
            $display("FAIL %s: data=%h ovr=%b expected data=%h ovr=%b", req, data_o, ovr_o, ed, eo);
        end
    endtask

    task automatic check_oe(input string req, input logic on);
        checks++;
        if (data_oe !== {OUT_W{on}} || ovr_oe !== on) begin
            fails++;
            $display("FAIL %s: data_oe=%h ovr_oe=%b expected data_oe=%h ovr_oe=%b",
                     req, data_oe, ovr_oe, {OUT_W{on}}, on);
        end
    endtask

    // Drive one word after a falling edge; outputs are sampled at the next falling edge.
    task automatic apply(input logic v, input logic [IN_W-1:0] c);
        @(negedge clk);
        in_valid = v;
        in_code  = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_word("R8 reset state", 10'h000, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(1'b1, VEC[i][21:11]);
            check_word("R1/R2/R3/R9 vector", VEC[i][10:1], VEC[i][0]);
        end

        // R5: no valid, word holds
        apply(1'b0, 11'd77);
        check_word("R5 hold", 10'h3FE, 1'b0);
        apply(1'b0, 11'd1800);
        check_word("R5 hold overrange input", 10'h3FE, 1'b0);

        // R4: not visible before the edge
        @(negedge clk);
        in_valid = 1'b1;
        in_code  = 11'd300;
        #2;
        check_word("R4 before edge", 10'h3FE, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check_word("R4 after edge", 10'd300, 1'b0);

        // R6: drive enables
        check_oe("R6 enabled", 1'b1);
        @(negedge clk);
        out_en_n = 1'b1;
        #1;
        check_oe("R6 released", 1'b0);

        // R7: capture while released, then re-enable
        apply(1'b1, 11'd1300);
        check_oe("R6 still released", 1'b0);
        apply(1'b1, 11'd640);
        @(negedge clk);
        out_en_n = 1'b0;
        #1;
        check_oe("R6 re-enabled", 1'b1);
        check_word("R7 word captured while released", 10'd640, 1'b0);

        // R8: reset from an overrange word
        apply(1'b1, 11'd2000);
        check_word("R2 before reset", 10'h3FF, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_word("R8 reset clears", 10'h000, 1'b0);
        rst = 1'b0;
        apply(1'b1, 11'd1023);
        check_word("R1 after reset", 10'h3FF, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule